// File: doc/BRIEF.md
# Chip-Select Toggle Watchdog

This block watches a host processor through one cheap signal: its serial chip-select line. The host keeps the watchdog happy by flipping chip-select now and then. No serial transfer has to go with the flip. A slow timebase tick drives a counter. If the host lets `TIMEOUT_TICKS` ticks pass while the watchdog is armed and chip-select has not changed, the block does three things:
- it drives a CPU reset pulse that lasts `RST_CYCLES` clocks;
- it sets a sticky failure flag for the status register;
- it disarms itself.

Reading the status register clears the flag. The watchdog can be armed again only after that read. Any enable write made while the flag is still set is discarded.

A power-down request also drives the CPU reset output, for as long as the request is held. While power-down is held the timeout counter stays at zero. Chip-select is treated as asynchronous: it passes through a synchronizer of `SYNC_STAGES` flops before either of its edges is detected.

Top module: `cs_kick_watchdog`

## Requirements
- R1: After synchronous reset, `cpu_rst_o`, `wd_flag_o` and `wd_en_o` are all 0.
- R2: A cycle with `en_wr_i`=1 while `wd_flag_o`=0 loads `en_val_i` into the enable bit, and `wd_en_o` shows the new value after the next clock edge.
- R3: While `wd_en_o`=0, no number of timebase ticks produces a CPU reset or sets `wd_flag_o`.
- R4: While armed, the `TIMEOUT_TICKS`-th tick since arming or since the last chip-select edge raises `cpu_rst_o` and `wd_flag_o` and clears `wd_en_o`. All three change on the clock edge that samples that tick.
- R5: A rising or a falling edge on `cs_n_i` restarts the tick count from zero. This holds once the edge has passed `SYNC_STAGES` synchronizer flops and one edge-detect flop, that is, `SYNC_STAGES`+1 clocks after the change.
- R6: A timeout drives `cpu_rst_o` high for exactly `RST_CYCLES` consecutive clocks.
- R7: A cycle with `stat_rd_i`=1 clears `wd_flag_o` on the next edge. If a timeout happens in that same cycle, the flag is set instead.
- R8: An enable write made while `wd_flag_o`=1 is ignored: `wd_en_o` stays 0 and later ticks produce no reset.
- R9: With `pdown_i`=1, `cpu_rst_o` is high from one clock after the request rises until one clock after it falls. The tick count is held at zero during this time, so after release a full `TIMEOUT_TICKS` window is needed.
- R10: After a failure followed by a status read, an enable write arms the watchdog again, and it times out after a full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| cs_n_i | input | 1 | Asynchronous chip-select line; either edge services the watchdog |
| tick_i | input | 1 | One-clock timebase tick |
| en_wr_i | input | 1 | Write strobe for the watchdog enable bit |
| en_val_i | input | 1 | Value written to the enable bit |
| pdown_i | input | 1 | Power-down request, level |
| stat_rd_i | input | 1 | Status-register read strobe, one clock |
| cpu_rst_o | output | 1 | CPU reset output, active high |
| wd_flag_o | output | 1 | Watchdog failure flag (status bit 6) |
| wd_en_o | output | 1 | Current watchdog enable bit |

## Verification
The assertions assume the following about the inputs:
- `tick_i`, `en_wr_i` and `stat_rd_i` are synchronous to `clk`.
- `rst` is high from time zero until the first clock edges have passed.
- Only `cs_n_i` may change at any time.

The stimulus drives every input on the falling clock edge. Each tick and strobe is held for exactly one cycle. After each chip-select change the stimulus waits out the synchronizer latency before it gives the next tick, so every kick is counted as landing between two ticks.

// File: rtl/cs_wd_pkg.sv
package cs_wd_pkg;
  localparam int unsigned DEF_TIMEOUT_TICKS = 3;
  localparam int unsigned DEF_RST_CYCLES    = 8;
  localparam int unsigned DEF_SYNC_STAGES   = 2;

  function automatic int unsigned width_for(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync #(
  parameter int unsigned STAGES = cs_wd_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q[0] <= line_i;
      for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
      last_q <= sh_q[STAGES-1];
    end
  end

  // either polarity of change counts as a kick
  assign edge_o = sh_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wd_tick_counter.sv
module wd_tick_counter #(
  parameter int unsigned LIMIT = cs_wd_pkg::DEF_TIMEOUT_TICKS
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic kick_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned   W    = cs_wd_pkg::width_for(LIMIT);
  localparam logic [W-1:0]  LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // a kick in the same cycle as the final tick wins
  assign expire_o = run_i && !kick_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || kick_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: a kick while running restarts the window
  a_r5_kick_restarts: assert property (@(posedge clk) disable iff (rst)
    (run_i && kick_i) |=> (cnt_q == '0));
  // R3/R9: nothing accumulates while stopped or held
  a_r3_idle_counter: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
  // R4: the count never passes the window
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt_q) < LIMIT));
endmodule

// File: rtl/wd_reset_stretch.sv
module wd_reset_stretch #(
  parameter int unsigned LEN = cs_wd_pkg::DEF_RST_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic pdown_i,
  output logic busy_o,
  output logic pd_o,
  output logic rst_o
);
  localparam int unsigned  W    = cs_wd_pkg::width_for(LEN);
  localparam logic [W-1:0] LOAD = W'(LEN);

  logic [W-1:0] pcnt_q;
  logic         pd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      pd_q   <= 1'b0;
    end else begin
      pd_q <= pdown_i;
      if (fire_i)              pcnt_q <= LOAD;
      else if (pcnt_q != '0)   pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign busy_o = (pcnt_q != '0);
  assign pd_o   = pd_q;
  assign rst_o  = busy_o | pd_q;

  // R6: pulse is loaded to full length and ends cleanly
  a_r6_pulse_load: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> (pcnt_q == LOAD));
  a_r6_pulse_ends: assert property (@(posedge clk) disable iff (rst)
    (pcnt_q == W'(1) && !fire_i) |=> (pcnt_q == '0));
endmodule

// File: rtl/cs_kick_watchdog.sv
module cs_kick_watchdog #(
  parameter int unsigned TIMEOUT_TICKS = cs_wd_pkg::DEF_TIMEOUT_TICKS,
  parameter int unsigned RST_CYCLES    = cs_wd_pkg::DEF_RST_CYCLES,
  parameter int unsigned SYNC_STAGES   = cs_wd_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic tick_i,
  input  logic en_wr_i,
  input  logic en_val_i,
  input  logic pdown_i,
  input  logic stat_rd_i,
  output logic cpu_rst_o,
  output logic wd_flag_o,
  output logic wd_en_o
);
  logic kick, expire, busy, pd_held, run;
  logic en_q, flag_q;

  cs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(cs_n_i), .edge_o(kick)
  );

  assign run = en_q && !busy && !pd_held;

  wd_tick_counter #(.LIMIT(TIMEOUT_TICKS)) u_cnt (
    .clk(clk), .rst(rst), .run_i(run), .kick_i(kick),
    .tick_i(tick_i), .expire_o(expire)
  );

  wd_reset_stretch #(.LEN(RST_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .fire_i(expire), .pdown_i(pdown_i),
    .busy_o(busy), .pd_o(pd_held), .rst_o(cpu_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
      en_q   <= 1'b0;
    end else begin
      if (stat_rd_i)              flag_q <= 1'b0;
      if (en_wr_i && !flag_q)     en_q   <= en_val_i;
    end
  end

  assign wd_flag_o = flag_q;
  assign wd_en_o   = en_q;

  // R4: a timeout flags, disarms and resets together
  a_r4_expire_effects: assert property (@(posedge clk) disable iff (rst)
    expire |=> (wd_flag_o && !wd_en_o && cpu_rst_o));
  // R8: arming is locked out while the flag is unread
  a_r8_locked_out: assert property (@(posedge clk) disable iff (rst)
    wd_flag_o |=> !wd_en_o);
  // R7: a read without a coincident timeout clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && !expire) |=> !wd_flag_o);
  // R9: power-down reaches the reset output one clock later
  a_r9_pdown_resets: assert property (@(posedge clk) disable iff (rst)
    pdown_i |=> cpu_rst_o);
endmodule

// File: tb/cs_kick_watchdog_tb.sv
module cs_kick_watchdog_tb;
  localparam int unsigned TO = 3;
  localparam int unsigned RC = 8;
  localparam int unsigned SS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, tick = 1'b0, en_wr = 1'b0, en_val = 1'b0;
  logic pdown = 1'b0, stat_rd = 1'b0;
  logic cpu_rst, wd_flag, wd_en;
  int   n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  cs_kick_watchdog #(.TIMEOUT_TICKS(TO), .RST_CYCLES(RC), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .tick_i(tick), .en_wr_i(en_wr),
    .en_val_i(en_val), .pdown_i(pdown), .stat_rd_i(stat_rd),
    .cpu_rst_o(cpu_rst), .wd_flag_o(wd_flag), .wd_en_o(wd_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic write_en(input logic v);
    @(negedge clk) begin en_wr = 1'b1; en_val = v; end
    @(negedge clk) en_wr = 1'b0;
  endtask

  task automatic read_stat();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic toggle_cs();
    @(negedge clk) cs_n = ~cs_n;
    repeat (SS + 2) @(negedge clk);
  endtask

  task automatic wait_pulse_end();
    for (int i = 0; i < 100 && cpu_rst; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 cpu_rst", cpu_rst, 0);
    check("R1 flag", wd_flag, 0);
    check("R1 enable", wd_en, 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    for (int i = 0; i < 2 * TO; i++) begin
      pulse_tick();
      if (cpu_rst) seen++;
    end
    check("R3 no reset while disabled", seen, 0);
    check("R3 flag stays clear", wd_flag, 0);
    write_en(1'b1);
    write_en(1'b0);
    check("R2 enable cleared by write", wd_en, 0);
    seen = 0;
    for (int i = 0; i < 2 * TO; i++) begin
      pulse_tick();
      if (cpu_rst) seen++;
    end
    check("R3 no reset after disable", seen, 0);
  endtask

  task automatic t_timeout();
    int len = 0;
    write_en(1'b1);
    check("R2 enable set", wd_en, 1);
    for (int i = 0; i < TO - 1; i++) pulse_tick();
    check("R4 no reset before window", cpu_rst, 0);
    pulse_tick();
    check("R4 reset at window", cpu_rst, 1);
    check("R4 flag set", wd_flag, 1);
    check("R4 enable cleared", wd_en, 0);
    while (cpu_rst && len < 100) begin
      len++;
      @(negedge clk);
    end
    check("R6 pulse length", len, RC);
  endtask

  task automatic t_locked();
    int seen = 0;
    write_en(1'b1);
    check("R8 enable write ignored", wd_en, 0);
    for (int i = 0; i < TO + 1; i++) begin
      pulse_tick();
      if (cpu_rst) seen++;
    end
    check("R8 no reset after ignored write", seen, 0);
    read_stat();
    check("R7 read clears flag", wd_flag, 0);
    write_en(1'b1);
    check("R10 re-arm after read", wd_en, 1);
    for (int i = 0; i < TO - 1; i++) pulse_tick();
    check("R10 full window needed", cpu_rst, 0);
    pulse_tick();
    check("R10 timeout after re-arm", cpu_rst, 1);
    wait_pulse_end();
    read_stat();
  endtask

  task automatic t_kick();
    write_en(1'b1);
    for (int i = 0; i < TO - 1; i++) pulse_tick();
    toggle_cs();
    for (int i = 0; i < TO - 1; i++) pulse_tick();
    check("R5 first edge restarts count", cpu_rst, 0);
    toggle_cs();
    for (int i = 0; i < TO - 1; i++) pulse_tick();
    check("R5 second edge restarts count", cpu_rst, 0);
    pulse_tick();
    check("R5 timeout after kicks stop", cpu_rst, 1);
    wait_pulse_end();
    read_stat();
  endtask

  task automatic t_read_race();
    write_en(1'b1);
    for (int i = 0; i < TO - 1; i++) pulse_tick();
    @(negedge clk) begin tick = 1'b1; stat_rd = 1'b1; end
    @(negedge clk) begin tick = 1'b0; stat_rd = 1'b0; end
    check("R7 timeout beats read", wd_flag, 1);
    wait_pulse_end();
    read_stat();
    check("R7 later read clears", wd_flag, 0);
  endtask

  task automatic t_pdown();
    int low = 0;
    write_en(1'b1);
    pulse_tick();
    @(negedge clk) pdown = 1'b1;
    @(negedge clk);
    check("R9 reset follows power-down", cpu_rst, 1);
    for (int i = 0; i < TO + 2; i++) begin
      pulse_tick();
      if (!cpu_rst) low++;
    end
    check("R9 reset held during power-down", low, 0);
    check("R9 no timeout during power-down", wd_flag, 0);
    @(negedge clk) pdown = 1'b0;
    @(negedge clk);
    check("R9 reset released", cpu_rst, 0);
    for (int i = 0; i < TO - 1; i++) pulse_tick();
    check("R9 count held at zero", cpu_rst, 0);
    pulse_tick();
    check("R9 full window after release", cpu_rst, 1);
    wait_pulse_end();
    read_stat();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_timeout();
    t_locked();
    t_kick();
    t_read_race();
    t_pdown();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule